// File: doc/BRIEF.md
# Empty-Column-First Input Scheduler

This block is the arbiter that sits on one input line card of a buffered crossbar switch with N ports. In every cell slot it chooses at most one virtual output queue (VOQ) of its input. The head cell of that queue then moves into the crosspoint buffer that belongs to this input and the chosen output. The queue memories, the cell datapath and the crosspoint buffers are not part of the block. It sees only their status: one bit per output that says a queue holds cells, one bit per output that says this row's crosspoint buffer is full, and one bit per output that says every crosspoint buffer in that output's column is empty.

A queue may be chosen only when it holds a cell and its crosspoint buffer has room. Among the eligible queues, the block prefers a queue whose output column is completely drained, because that output would otherwise go idle. It falls back to a rotating-pointer round-robin choice only when no such queue exists. The pointer moves only after a round-robin choice. When the remove enable is set, the block also sends one remove-request toward the output it granted.

Every cycle is one cell slot. The decision is registered, so the grant seen on the outputs reflects the status inputs sampled at the preceding rising clock edge.

Top module: `ecf_input_scheduler`

## Requirements
- R1: After reset, the grant, the grant-valid flag and the remove-request are all zero, and the round-robin pointer is 0: the first round-robin decision favours output 0.
- R2: A queue for output j is eligible only when `voqNonEmpty[j]` is 1 and `xbufFull[j]` is 0. A queue that is not eligible is never granted.
- R3: If any eligible queue has `columnEmpty` set for its output, the grant goes to one of those queues, even when the pointer favours another eligible queue.
- R4: When several eligible queues have empty columns, the grant goes to the first of them in the order pointer, pointer+1, …, wrapping modulo N.
- R5: When no eligible queue has an empty column, the grant goes to the first eligible queue in the order pointer, pointer+1, …, wrapping modulo N.
- R6: After a round-robin grant to output g, the pointer becomes (g+1) mod N. This includes the wrap from N-1 to 0.
- R7: After a grant made on the empty-column path, the pointer keeps its value.
- R8: With no eligible queue, `grantValid` is 0, `grantVec` is all zeros and the pointer keeps its value.
- R9: `removeReq` equals `grantVec` when `removeEnable` was 1 in the deciding slot, and is all zeros otherwise. At most one of its bits is set.
- R10: The outputs are registered. The values present after a rising edge are the decision for the inputs sampled at that edge. Whenever `grantValid` is 1, `grantVec` is one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one decision per rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| voqNonEmpty | input | NUM_PORTS | Bit j set: the queue toward output j holds a cell |
| xbufFull | input | NUM_PORTS | Bit j set: this input's crosspoint buffer for output j has no room |
| columnEmpty | input | NUM_PORTS | Bit j set: every crosspoint buffer in output j's column is empty |
| removeEnable | input | 1 | Allows a remove-request toward the granted output |
| grantVec | output | NUM_PORTS | One-hot grant; bit j selects the queue toward output j |
| grantValid | output | 1 | A grant was issued in this slot |
| removeReq | output | NUM_PORTS | One-hot remove-request toward the granted output, or zero |

## Verification
The bench steers the pointer to each position and then offers empty columns both before and after the pointer. A design that scans from index 0, or from the wrong end, grants the wrong queue in that case. It places a drained column on a queue whose crosspoint buffer is full, and on an empty queue. A design that skips the eligibility mask grants a queue that cannot send. Right after empty-column grants and idle slots, it runs round-robin slots to expose a pointer that moves when it should hold, and it checks the wrap from the last output back to 0. The remove-request is compared with the grant with the enable both set and cleared, and in slots with no eligible queue, so a request that leaks or sticks shows up.

// File: rtl/ecf_sched_pkg.sv
package ecf_sched_pkg;

  // Strobes from the control module to the datapath for one slot.
  typedef struct packed {
    logic issue;       // a grant is made this slot
    logic useColumn;   // take the empty-column arbiter's result
    logic advancePtr;  // move the rotating pointer past the grant
    logic sendRemove;  // mirror the grant onto the remove-request
  } ecfStrobes_t;

endpackage

// File: rtl/ecf_rr_arbiter.sv
module ecf_rr_arbiter #(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] reqVec,
  input  logic [IDX_W-1:0]     basePtr,
  output logic [NUM_PORTS-1:0] gntVec,
  output logic                 anyGnt
);

  // Walk from basePtr upward, wrapping, and take the first request.
  always_comb begin
    logic found;
    gntVec = '0;
    found  = 1'b0;
    for (int off = 0; off < NUM_PORTS; off++) begin
      int idx;
      idx = (int'(basePtr) + off) % NUM_PORTS;
      if (!found && reqVec[idx]) begin
        gntVec[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign anyGnt = |reqVec;

endmodule

// File: rtl/ecf_control.sv
module ecf_control
  import ecf_sched_pkg::*;
(
  input  logic        anyEligible,
  input  logic        anyColumnEligible,
  input  logic        removeEnable,
  output ecfStrobes_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.issue      = anyEligible;
    strobes.useColumn  = anyColumnEligible;
    strobes.advancePtr = anyEligible && !anyColumnEligible;
    strobes.sendRemove = anyEligible && removeEnable;
  end

endmodule

// File: rtl/ecf_datapath.sv
module ecf_datapath
  import ecf_sched_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] voqNonEmpty,
  input  logic [NUM_PORTS-1:0] xbufFull,
  input  logic [NUM_PORTS-1:0] columnEmpty,
  input  ecfStrobes_t          strobes,
  output logic                 anyEligible,
  output logic                 anyColumnEligible,
  output logic [NUM_PORTS-1:0] grantVec,
  output logic                 grantValid,
  output logic [NUM_PORTS-1:0] removeReq
);

  logic [NUM_PORTS-1:0] eligVec;
  logic [NUM_PORTS-1:0] colEligVec;
  logic [NUM_PORTS-1:0] colGnt;
  logic [NUM_PORTS-1:0] rrGnt;
  logic [NUM_PORTS-1:0] mergedGnt;
  logic [IDX_W-1:0]     rrPtr;
  logic [IDX_W-1:0]     ptrNext;

  assign eligVec    = voqNonEmpty & ~xbufFull;
  assign colEligVec = eligVec & columnEmpty;

  ecf_rr_arbiter #(.NUM_PORTS(NUM_PORTS)) u_colArb (
    .reqVec  (colEligVec),
    .basePtr (rrPtr),
    .gntVec  (colGnt),
    .anyGnt  (anyColumnEligible)
  );

  ecf_rr_arbiter #(.NUM_PORTS(NUM_PORTS)) u_rrArb (
    .reqVec  (eligVec),
    .basePtr (rrPtr),
    .gntVec  (rrGnt),
    .anyGnt  (anyEligible)
  );

  // One selector per output merges the two arbiters' results.
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
    assign mergedGnt[g] = strobes.issue &&
                          (strobes.useColumn ? colGnt[g] : rrGnt[g]);
  end

  always_comb begin
    ptrNext = rrPtr;
    if (strobes.advancePtr) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (rrGnt[i]) ptrNext = IDX_W'((i + 1) % NUM_PORTS);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr      <= '0;
      grantVec   <= '0;
      grantValid <= 1'b0;
      removeReq  <= '0;
    end else begin
      rrPtr      <= ptrNext;
      grantVec   <= mergedGnt;
      grantValid <= strobes.issue;
      removeReq  <= strobes.sendRemove ? mergedGnt : '0;
    end
  end

endmodule

// File: rtl/ecf_input_scheduler.sv
module ecf_input_scheduler
  import ecf_sched_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] voqNonEmpty,
  input  logic [NUM_PORTS-1:0] xbufFull,
  input  logic [NUM_PORTS-1:0] columnEmpty,
  input  logic                 removeEnable,
  output logic [NUM_PORTS-1:0] grantVec,
  output logic                 grantValid,
  output logic [NUM_PORTS-1:0] removeReq
);

  ecfStrobes_t strobes;
  logic        anyEligible;
  logic        anyColumnEligible;

  ecf_control u_control (
    .anyEligible       (anyEligible),
    .anyColumnEligible (anyColumnEligible),
    .removeEnable      (removeEnable),
    .strobes           (strobes)
  );

  ecf_datapath #(.NUM_PORTS(NUM_PORTS)) u_datapath (
    .clk               (clk),
    .rstN              (rstN),
    .voqNonEmpty       (voqNonEmpty),
    .xbufFull          (xbufFull),
    .columnEmpty       (columnEmpty),
    .strobes           (strobes),
    .anyEligible       (anyEligible),
    .anyColumnEligible (anyColumnEligible),
    .grantVec          (grantVec),
    .grantValid        (grantValid),
    .removeReq         (removeReq)
  );

endmodule

// File: rtl/ecf_input_scheduler_checker.sv
module ecf_input_scheduler_checker #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] voqNonEmpty,
  input logic [NUM_PORTS-1:0] xbufFull,
  input logic [NUM_PORTS-1:0] columnEmpty,
  input logic                 removeEnable,
  input logic [NUM_PORTS-1:0] grantVec,
  input logic                 grantValid,
  input logic [NUM_PORTS-1:0] removeReq
);

  // R10: a valid grant names exactly one queue
  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($countones(grantVec) == 1));

  // R8: no grant bits without the valid flag
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantVec == '0));

  // R2: the granted queue was eligible in the deciding slot
  assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((grantVec & ~$past(voqNonEmpty & ~xbufFull)) == '0));

  // R3: a drained column with an eligible queue wins the slot
  assert_empty_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|$past(voqNonEmpty & ~xbufFull & columnEmpty)) |->
      (grantValid && (|(grantVec & $past(columnEmpty)))));

  // R8: nothing eligible means no grant
  assert_no_elig_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(|$past(voqNonEmpty & ~xbufFull)) |-> !grantValid);

  // R9: remove-request follows the grant only when enabled
  assert_remove_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    removeReq == ($past(removeEnable) ? grantVec : '0));

  // R9: at most one remove-request per slot
  assert_remove_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(removeReq));

endmodule

bind ecf_input_scheduler ecf_input_scheduler_checker #(.NUM_PORTS(NUM_PORTS)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .voqNonEmpty  (voqNonEmpty),
  .xbufFull     (xbufFull),
  .columnEmpty  (columnEmpty),
  .removeEnable (removeEnable),
  .grantVec     (grantVec),
  .grantValid   (grantValid),
  .removeReq    (removeReq)
);

// File: tb/ecf_input_scheduler_bench.sv
`timescale 1ns/1ps
module ecf_input_scheduler_bench;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] voqNonEmpty = '0;
  logic [N-1:0] xbufFull = '0;
  logic [N-1:0] columnEmpty = '0;
  logic         removeEnable = 1'b0;
  logic [N-1:0] grantVec;
  logic         grantValid;
  logic [N-1:0] removeReq;

  int checks = 0;
  int failures = 0;
  int modelPtr = 0;

  always #2.5 clk = ~clk;

  ecf_input_scheduler #(.NUM_PORTS(N)) u_ecf_input_scheduler (
    .clk          (clk),
    .rstN         (rstN),
    .voqNonEmpty  (voqNonEmpty),
    .xbufFull     (xbufFull),
    .columnEmpty  (columnEmpty),
    .removeEnable (removeEnable),
    .grantVec     (grantVec),
    .grantValid   (grantValid),
    .removeReq    (removeReq)
  );

  function automatic logic [N-1:0] pickFrom(logic [N-1:0] req, int ptr);
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (ptr + off) % N;
      if (req[idx]) return N'(1) << idx;
    end
    return '0;
  endfunction

  function automatic int indexOf(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic checkVal(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  // Drive one slot at a falling edge, let a rising edge capture it, then
  // compare the registered outputs with the model at the next falling edge.
  task automatic runSlot(logic [N-1:0] ne, logic [N-1:0] full, logic [N-1:0] col,
                         logic rem, string tag);
    logic [N-1:0] elig, colElig, expG, expR;
    voqNonEmpty  = ne;
    xbufFull     = full;
    columnEmpty  = col;
    removeEnable = rem;
    elig    = ne & ~full;
    colElig = elig & col;
    if (colElig != '0) begin
      expG = pickFrom(colElig, modelPtr);
    end else if (elig != '0) begin
      expG = pickFrom(elig, modelPtr);
      modelPtr = (indexOf(expG) + 1) % N;
    end else begin
      expG = '0;
    end
    expR = rem ? expG : '0;
    @(negedge clk);
    checkVal(tag, "grantVec", int'(grantVec), int'(expG));
    checkVal(tag, "grantValid", int'(grantValid), int'(expG != '0));
    checkVal(tag, "removeReq", int'(removeReq), int'(expR));
  endtask

  task automatic testReset();
    // R1: reset state, then first round-robin pick is output 0
    checkVal("R1", "grantVec", int'(grantVec), 0);
    checkVal("R1", "grantValid", int'(grantValid), 0);
    checkVal("R1", "removeReq", int'(removeReq), 0);
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R1");
  endtask

  task automatic testRoundRobin();
    // R5/R6: rotation through every output with wrap back to 0
    for (int k = 0; k < N + 1; k++) runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R6");
    runSlot(4'b1010, 4'b0000, 4'b0000, 1'b0, "R5");
    runSlot(4'b1010, 4'b0000, 4'b0000, 1'b0, "R5");
  endtask

  task automatic testEligibility();
    // R2: full buffers and empty queues mask out, even on drained columns
    runSlot(4'b1111, 4'b0111, 4'b0000, 1'b0, "R2");
    runSlot(4'b1110, 4'b0001, 4'b0011, 1'b0, "R2");
    runSlot(4'b0110, 4'b0010, 4'b0011, 1'b0, "R2");
  endtask

  task automatic testColumnFirst();
    // R3/R7: drained column wins; pointer untouched afterwards
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R5");
    runSlot(4'b1111, 4'b0000, 4'b1000, 1'b0, "R3");
    runSlot(4'b1111, 4'b0000, 4'b0001, 1'b0, "R3");
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R7");
  endtask

  task automatic testColumnOrder();
    // R4: several drained columns, from each pointer position
    for (int p = 0; p < N; p++) begin
      runSlot(4'b1111, 4'b0000, 4'b1001, 1'b0, "R4");
      runSlot(4'b1111, 4'b0000, 4'b0110, 1'b0, "R4");
      runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R7");
    end
  endtask

  task automatic testIdle();
    // R8: nothing eligible, then pointer shown to have held
    runSlot(4'b0000, 4'b0000, 4'b1111, 1'b1, "R8");
    runSlot(4'b1111, 4'b1111, 4'b0000, 1'b0, "R8");
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R8");
  endtask

  task automatic testRemove();
    // R9: mirror of the grant only when enabled
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b1, "R9");
    runSlot(4'b1111, 4'b0000, 4'b0100, 1'b1, "R9");
    runSlot(4'b1111, 4'b0000, 4'b0000, 1'b0, "R9");
    runSlot(4'b0000, 4'b0000, 4'b0000, 1'b1, "R9");
    runSlot(4'b0011, 4'b0000, 4'b0000, 1'b1, "R10");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRoundRobin();
    testEligibility();
    testColumnFirst();
    testColumnOrder();
    testIdle();
    testRemove();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule